// File: doc/BRIEF.md
# Smart Card Receive Parity Checker

This block checks the parity of every character taken in on a smart card receive path. Each character arrives as eight data bits and one parity bit, qualified by a one-cycle valid strobe. One cycle after each valid character the block gives a one-cycle parity-bad pulse, which the surrounding receiver can use to ask the card to send the character again. It also keeps a sticky parity-error flag for the host, which stays set until the host clears it.

When the flag is raised depends on the protocol select. In block-oriented mode the first bad character raises it. In character-oriented mode it rises only after a run of consecutive bad characters, and the run length is programmed through a 3-bit threshold code. A test control inverts the parity rule, so that the bench or the system can check that the card side reacts to signalled parity errors.

Top module: `sc_parity_chk`

## Requirements
- R1: With `inv_par`=0, a character is good when the XOR of `rx_data[7:0]` and `rx_par` is 0 (even parity over nine bits). `par_bad` is 1 in the cycle after a valid character exactly when that character is bad.
- R2: With `inv_par`=1, the rule is inverted: a character is bad when the nine-bit XOR is 0.
- R3: `par_bad` is 0 in every cycle that does not follow a valid character.
- R4: With `proto_blk`=1 (block mode), `par_err_flag` is set in the cycle after the first bad character, whatever the value of `err_thresh`.
- R5: With `proto_blk`=0 (character mode), `par_err_flag` is set in the cycle after the Nth+1 consecutive bad character, where N is the value of `err_thresh` (0 to 7, so 1 to 8 errors).
- R6: A valid good character resets the consecutive-error run to zero.
- R7: A `flag_clr` strobe clears `par_err_flag` on the next cycle and resets the run. A bad character that arrives in the same cycle counts as the first of a new run.
- R8: Once set, `par_err_flag` stays at 1 through good characters and idle cycles until `flag_clr`.
- R9: If `flag_clr` and a character that qualifies to set the flag arrive in the same cycle, `par_err_flag` stays at 1.
- R10: While reset is held and right after it, `par_bad` and `par_err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received data bits |
| rx_par | input | 1 | Received parity bit |
| proto_blk | input | 1 | 1 = block-oriented protocol, 0 = character-oriented |
| err_thresh | input | 3 | Consecutive-error code N; the flag needs N+1 errors |
| inv_par | input | 1 | 1 = inverted parity is treated as correct |
| flag_clr | input | 1 | Host clear strobe for the sticky flag |
| par_bad | output | 1 | One-cycle pulse after each bad character |
| par_err_flag | output | 1 | Sticky parity-error flag |

## Verification
Data bytes with even and odd bit counts, each paired with both parity-bit values and both settings of the inverse control, show whether the parity rule or only its polarity is wrong. Runs of bad characters just below, at and just above the threshold (codes 0, 2 and 7) show off-by-one errors in the code-to-count mapping. A good character in the middle of a run shows whether the run is reset. The same runs in block mode with a high threshold show whether the threshold leaks into that mode. Clears that arrive alone, together with a first error, and together with a qualifying error show how the clear and the set are ordered.

// File: rtl/sc_parity_pkg.sv
package sc_parity_pkg;
   typedef enum logic {
      PROTO_CHAR  = 1'b0,
      PROTO_BLOCK = 1'b1
   } proto_e;
endpackage

// File: rtl/sc_parity_eval.sv
module sc_parity_eval #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              par_i,
   input  logic              inv_i,
   output logic              bad_o
);
   if (DATA_W < 1) begin : g_chk_w
      $error("sc_parity_eval: DATA_W must be at least 1");
   end

   logic [DATA_W:0] chain;
   assign chain[0] = par_i;
   for (genvar i = 0; i < DATA_W; i++) begin : g_xor
      assign chain[i+1] = chain[i] ^ data_i[i];
   end

   assign bad_o = chain[DATA_W] ^ inv_i;
endmodule

// File: rtl/sc_err_run.sv
module sc_err_run #(
   parameter int THR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             bad_i,
   input  logic             clr_i,
   input  logic             blk_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             qualify_o
);
   localparam int RUN_MAX = 2 ** THR_W;
   localparam int CNT_W   = $clog2(RUN_MAX + 1);

   if (THR_W < 1 || THR_W > 8) begin : g_chk_thr
      $error("sc_err_run: THR_W out of range");
   end

   logic [CNT_W-1:0] run_q, base, inc, limit;

   assign base  = clr_i ? '0 : run_q;
   assign inc   = (base == CNT_W'(RUN_MAX)) ? base : base + 1'b1;
   assign limit = {{(CNT_W-THR_W){1'b0}}, thr_i} + 1'b1;

   assign qualify_o = valid_i & bad_i & (blk_i | (inc >= limit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (valid_i) run_q <= bad_i ? inc : '0;
      else              run_q <= base;
   end

   // R6
   good_resets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !bad_i) |=> (run_q == '0));

   // R7
   clr_resets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !valid_i) |=> (run_q == '0));
endmodule

// File: rtl/sc_parity_chk.sv
module sc_parity_chk
   import sc_parity_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int THR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par,
   input  logic              proto_blk,
   input  logic [THR_W-1:0]  err_thresh,
   input  logic              inv_par,
   input  logic              flag_clr,
   output logic              par_bad,
   output logic              par_err_flag
);
   proto_e proto;
   logic   bad_now, qualify;

   assign proto = proto_e'(proto_blk);

   sc_parity_eval #(.DATA_W(DATA_W)) u_eval (
      .data_i (rx_data),
      .par_i  (rx_par),
      .inv_i  (inv_par),
      .bad_o  (bad_now)
   );

   sc_err_run #(.THR_W(THR_W)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (rx_valid),
      .bad_i     (bad_now),
      .clr_i     (flag_clr),
      .blk_i     (proto == PROTO_BLOCK),
      .thr_i     (err_thresh),
      .qualify_o (qualify)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_bad      <= 1'b0;
         par_err_flag <= 1'b0;
      end else begin
         par_bad <= rx_valid & bad_now;
         if (qualify)       par_err_flag <= 1'b1;
         else if (flag_clr) par_err_flag <= 1'b0;
      end
   end

   // R1
   parity_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (par_bad == $past((^rx_data) ^ rx_par ^ inv_par)));

   // R3
   no_spurious_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !par_bad);

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err_flag && !flag_clr) |=> par_err_flag);

   // R4
   flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err_flag) |-> par_bad);

   // R7
   clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !rx_valid) |=> !par_err_flag);
endmodule

// File: tb/tb_sc_parity_chk.sv
module tb_sc_parity_chk;
   localparam time CLK_PER = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_par = 1'b0;
   logic       proto_blk = 1'b0;
   logic [2:0] err_thresh = '0;
   logic       inv_par = 1'b0;
   logic       flag_clr = 1'b0;
   logic       par_bad, par_err_flag;

   int total = 0, bad = 0;
   int m_run = 0;
   bit m_flag = 0, m_bad = 0;
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   sc_parity_chk dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_par(rx_par), .proto_blk(proto_blk), .err_thresh(err_thresh),
      .inv_par(inv_par), .flag_clr(flag_clr),
      .par_bad(par_bad), .par_err_flag(par_err_flag)
   );

   task automatic check(string tag);
      total++;
      if (par_bad !== m_bad) begin
         bad++;
         $display("FAIL %s par_bad actual=%b expected=%b", tag, par_bad, m_bad);
      end
      total++;
      if (par_err_flag !== m_flag) begin
         bad++;
         $display("FAIL %s par_err_flag actual=%b expected=%b", tag, par_err_flag, m_flag);
      end
   endtask

   // Reference model: one clock of the requirements, then compare at negedge.
   task automatic step(string tag, bit v, logic [7:0] d, bit p, bit clr);
      bit cbad, qual;
      int base, inc;
      rx_valid = v; rx_data = d; rx_par = p; flag_clr = clr;
      cbad = ((^d) ^ p ^ inv_par) == 1'b1;
      base = clr ? 0 : m_run;
      inc  = (base >= 8) ? 8 : base + 1;
      qual = v && cbad && (proto_blk || inc >= int'(err_thresh) + 1);
      @(posedge clk);
      m_bad = v && cbad;
      if (v) m_run = cbad ? inc : 0; else m_run = base;
      if (qual) m_flag = 1; else if (clr) m_flag = 0;
      @(negedge clk);
      check(tag);
      rx_valid = 0; flag_clr = 0;
   endtask

   task automatic bad_char(string tag);  step(tag, 1, 8'h03, 1, 0); endtask
   task automatic good_char(string tag); step(tag, 1, 8'h03, 0, 0); endtask
   task automatic idle(string tag);      step(tag, 0, 8'h00, 0, 0); endtask
   task automatic clear(string tag);     step(tag, 0, 8'h00, 0, 1); endtask

   initial begin
      repeat (CLK_PER * 20000 / 1ns) #1ns;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 in reset");
      rst_n = 1;
      @(negedge clk);
      check("R10 after reset");

      // R1 even parity patterns, flag stays low: threshold 7
      err_thresh = 3'd7;
      step("R1 a5 p0", 1, 8'hA5, 0, 0);
      step("R1 a5 p1", 1, 8'hA5, 1, 0);
      step("R1 07 p1", 1, 8'h07, 1, 0);
      step("R1 07 p0", 1, 8'h07, 0, 0);
      step("R1 ff p0", 1, 8'hFF, 0, 0);
      step("R1 80 p1", 1, 8'h80, 1, 0);
      idle("R3 idle");
      idle("R3 idle");
      // R2 inverse parity
      inv_par = 1;
      step("R2 a5 p0", 1, 8'hA5, 0, 0);
      step("R2 07 p0", 1, 8'h07, 0, 0);
      step("R2 00 p0", 1, 8'h00, 0, 0);
      inv_par = 0;
      good_char("R6 reset run");
      clear("R7 clear");

      // R5 threshold code 0: first error
      err_thresh = 3'd0;
      bad_char("R5 thr0");
      good_char("R8 sticky good");
      idle("R8 sticky idle");
      clear("R7 clear");
      // R5 code 2: three errors
      err_thresh = 3'd2;
      bad_char("R5 thr2 1"); bad_char("R5 thr2 2");
      good_char("R6 break run");
      bad_char("R5 thr2 1"); bad_char("R5 thr2 2"); bad_char("R5 thr2 3");
      bad_char("R5 thr2 4");
      clear("R7 clear");
      // R5 code 7: eight errors
      err_thresh = 3'd7;
      for (int i = 0; i < 10; i++) bad_char("R5 thr7");
      // R9 clear with qualifying error (run saturated, threshold 7 needs fresh run)
      err_thresh = 3'd0;
      step("R9 clr+qual", 1, 8'h01, 0, 1);
      idle("R9 after");
      // R7 clear with a bad char starting a new run
      clear("R7 clear");
      err_thresh = 3'd1;
      bad_char("R5 thr1 1");
      step("R7 clr+bad", 1, 8'h01, 0, 1);
      bad_char("R7 run restart");
      clear("R7 clear");

      // R4 block mode ignores threshold
      proto_blk = 1; err_thresh = 3'd7;
      good_char("R4 good");
      bad_char("R4 first bad");
      bad_char("R4 more");
      step("R9 blk clr+bad", 1, 8'h00, 1, 1);
      clear("R7 blk clear");
      inv_par = 1;
      step("R4 R2 inv bad", 1, 8'h00, 0, 0);
      idle("R3 idle");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule